// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block connects a simple single-word request port to a DRAM device that shares one set of address pins between row and column. A request supplies a flat address, a direction, write data and a strobe. The controller latches the request and splits the address into a row part and a column part. It then walks a fixed sequence of timed phases on the pin side: row setup, row strobe, column setup, column strobe, data and precharge. A completed read or write is marked by a single-cycle ready pulse, and read data is returned together with that pulse.

An internal interval counter raises a refresh request at a fixed spacing. A pending refresh takes priority over new requests. It never cuts into an access that is already running; it waits until that access finishes. A refresh cycle strobes the row line with a row taken from an internal refresh row counter. It keeps the column strobe inactive and then moves the counter on by one. A two-bit status output tells the system whether the controller is idle, running an access, or busy with refresh. Requests are taken only while the status reads idle.

The state machine has ten states. The access path is IDLE -> ROW_SETUP -> RAS -> COL_SETUP -> CAS -> DATA -> PRECHARGE -> IDLE. The refresh path is IDLE -> REF_SETUP -> REF_RAS -> REF_PRECHARGE -> IDLE. IDLE moves to REF_SETUP when a refresh is pending. Otherwise it moves to ROW_SETUP when a request strobe is present. Every other state moves to its successor when its phase timer reaches the programmed length.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe, output enable and write enable pins (all active low) are high, status is 0 (idle) and the ready pulse is low.
- R2: The row address is the upper half of the flat address and the column address is the lower half. The row is on the shared address pins when the row strobe falls, and the column is on them when the column strobe falls.
- R3: The row strobe falls before the column strobe in every access, and the column strobe is low only while the row strobe is low.
- R4: In a write, write enable is low and the write data is driven on the data-out pins while the column strobe is low. In a read, output enable is low and write enable stays high. Output enable and write enable are never low together.
- R5: Each access ends with a ready pulse one cycle long. For a read, the read data presented with that pulse equals the stored word. From the clock edge that accepts the request to the edge after which ready is high takes T_ROW_SETUP+T_RAS+T_COL_SETUP+T_CAS+T_DATA cycles.
- R6: Status is encoded 0 = idle, 1 = access, 2 = refresh (active or pending). A request strobe is accepted only while the status is 0. A strobe raised while the status is 2 and dropped before it returns to 0 causes no access.
- R7: A refresh is requested every REF_INTERVAL clock cycles. A refresh cycle lowers only the row strobe (the column strobe stays high). It uses a row from a refresh row counter that increases by one per refresh and wraps.
- R8: A refresh that comes due during an access is held and runs after that access completes. No access is cut short, and data integrity holds under continuous back-to-back traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ready |
| status | output | 2 | 0 idle, 1 access, 2 refresh |
| dram_addr | output | PIN_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data towards the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the block with an 8-bit address and 8-bit data, so a full 256-word behavioural array fits in the bench. It keeps the default phase lengths, which include two-cycle strobe and data phases, so each phase counter has to count past its first cycle. The refresh interval is lowered to 60 cycles, which puts several refreshes inside a short idle wait. It also makes refreshes collide with a long run of back-to-back accesses and with a request strobe raised during refresh. The refresh row sequence can then be checked across several increments.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_RAS,
        ST_COL_SETUP,
        ST_CAS,
        ST_DATA,
        ST_PRECHARGE,
        ST_REF_SETUP,
        ST_REF_RAS,
        ST_REF_PRECHARGE
    } drc_state_e;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } drc_pin_sel_e;

    localparam logic [1:0] STAT_IDLE    = 2'd0;
    localparam logic [1:0] STAT_ACCESS  = 2'd1;
    localparam logic [1:0] STAT_REFRESH = 2'd2;

endpackage

// File: rtl/drc_refresh_timer.sv
module drc_refresh_timer #(
    parameter int REF_INTERVAL = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    logic [IW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == IW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

    // R8: a pending refresh stays pending until the state machine takes it
    a_r8_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);

endmodule

// File: rtl/drc_phase_timer.sv
module drc_phase_timer #(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] limit,
    output logic               last
);
    logic [PHASE_W-1:0] cnt;

    assign last = (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/drc_addr_path.sv
module drc_addr_path
    import drc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   addr_in,
    input  drc_pin_sel_e        sel,
    input  logic                ref_inc,
    output logic [((ADDR_W/2 > ADDR_W-ADDR_W/2) ? ADDR_W/2 : ADDR_W-ADDR_W/2)-1:0] pin_addr
);
    localparam int ROW_W = ADDR_W / 2;
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] ref_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            ref_row <= '0;
        end else begin
            if (load) begin
                row_q <= addr_in[ADDR_W-1 -: ROW_W];
                col_q <= addr_in[COL_W-1:0];
            end
            if (ref_inc)
                ref_row <= ref_row + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            PIN_COL: pin_addr = PIN_W'(col_q);
            PIN_REF: pin_addr = PIN_W'(ref_row);
            default: pin_addr = PIN_W'(row_q);
        endcase
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import drc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PHASE_W      = 4,
    parameter int T_ROW_SETUP  = 1,
    parameter int T_RAS        = 2,
    parameter int T_COL_SETUP  = 1,
    parameter int T_CAS        = 1,
    parameter int T_DATA       = 2,
    parameter int T_PRECHARGE  = 2,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 390,
    localparam int PIN_W = (ADDR_W/2 > ADDR_W-ADDR_W/2) ? ADDR_W/2 : ADDR_W-ADDR_W/2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        status,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_oe_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    drc_state_e         state, state_nx;
    drc_pin_sel_e       pin_sel;
    logic [PHASE_W-1:0] limit;
    logic               last;
    logic               ref_pending;
    logic               ref_ack;
    logic               accept;
    logic               ref_inc;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;

    assign ref_ack = (state == ST_IDLE) && ref_pending;
    assign accept  = (state == ST_IDLE) && !ref_pending && req_valid;
    assign ref_inc = (state == ST_REF_RAS) && last;

    drc_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    drc_phase_timer #(.PHASE_W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (limit),
        .last  (last)
    );

    drc_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .sel      (pin_sel),
        .ref_inc  (ref_inc),
        .pin_addr (dram_addr)
    );

    // phase length per state, programmed as length minus one
    always_comb begin
        unique case (state)
            ST_IDLE:          limit = '0;
            ST_ROW_SETUP:     limit = PHASE_W'(T_ROW_SETUP - 1);
            ST_RAS:           limit = PHASE_W'(T_RAS - 1);
            ST_COL_SETUP:     limit = PHASE_W'(T_COL_SETUP - 1);
            ST_CAS:           limit = PHASE_W'(T_CAS - 1);
            ST_DATA:          limit = PHASE_W'(T_DATA - 1);
            ST_PRECHARGE:     limit = PHASE_W'(T_PRECHARGE - 1);
            ST_REF_SETUP:     limit = PHASE_W'(T_ROW_SETUP - 1);
            ST_REF_RAS:       limit = PHASE_W'(T_REF_RAS - 1);
            ST_REF_PRECHARGE: limit = PHASE_W'(T_PRECHARGE - 1);
            default:          limit = '0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)
                    state_nx = ST_REF_SETUP;
                else if (req_valid)
                    state_nx = ST_ROW_SETUP;
            end
            ST_ROW_SETUP:     if (last) state_nx = ST_RAS;
            ST_RAS:           if (last) state_nx = ST_COL_SETUP;
            ST_COL_SETUP:     if (last) state_nx = ST_CAS;
            ST_CAS:           if (last) state_nx = ST_DATA;
            ST_DATA:          if (last) state_nx = ST_PRECHARGE;
            ST_PRECHARGE:     if (last) state_nx = ST_IDLE;
            ST_REF_SETUP:     if (last) state_nx = ST_REF_RAS;
            ST_REF_RAS:       if (last) state_nx = ST_REF_PRECHARGE;
            ST_REF_PRECHARGE: if (last) state_nx = ST_IDLE;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
        end
    end

    // completion pulse and read capture at the end of the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= (state == ST_DATA) && last;
            if ((state == ST_DATA) && last && !wr_q)
                rsp_rdata <= dram_dq_in;
        end
    end

    // pin and status outputs
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_oe_n   = 1'b1;
        dram_we_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_dq_out = wdata_q;
        pin_sel     = PIN_ROW;
        status      = STAT_ACCESS;
        unique case (state)
            ST_IDLE: begin
                status = ref_pending ? STAT_REFRESH : STAT_IDLE;
            end
            ST_ROW_SETUP: begin
                pin_sel = PIN_ROW;
            end
            ST_RAS: begin
                pin_sel    = PIN_ROW;
                dram_ras_n = 1'b0;
            end
            ST_COL_SETUP: begin
                pin_sel    = PIN_COL;
                dram_ras_n = 1'b0;
                dram_dq_oe = wr_q;
            end
            ST_CAS, ST_DATA: begin
                pin_sel    = PIN_COL;
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !wr_q;
                dram_oe_n  = wr_q;
                dram_dq_oe = wr_q;
            end
            ST_PRECHARGE: begin
                pin_sel = PIN_COL;
            end
            ST_REF_SETUP: begin
                pin_sel = PIN_REF;
                status  = STAT_REFRESH;
            end
            ST_REF_RAS: begin
                pin_sel    = PIN_REF;
                dram_ras_n = 1'b0;
                status     = STAT_REFRESH;
            end
            ST_REF_PRECHARGE: begin
                pin_sel = PIN_REF;
                status  = STAT_REFRESH;
            end
            default: begin
                status = STAT_IDLE;
            end
        endcase
    end

    // R3: column strobe only under an active row strobe
    a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R4: output enable and write enable never both active
    a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_oe_n && !dram_we_n));

    // R5: ready lasts a single cycle
    a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R7: refresh row strobe never comes with a column strobe
    a_r7_refresh_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_REFRESH) |-> dram_cas_n);

    // R6: an idle controller with refresh pending goes to refresh, not to an access
    a_r6_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pending) |=> (state == ST_REF_SETUP));

endmodule

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;

    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int PW  = 4;
    localparam int INT = 60;
    localparam int LAT = 1 + 2 + 1 + 1 + 2;  // default phase lengths
    localparam int NV  = 8;

    // {write, addr, data}: for reads the data field is the expected word
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 8'h3C, 8'hA5},
        {1'b1, 8'hC3, 8'h5A},
        {1'b0, 8'h3C, 8'hA5},
        {1'b0, 8'hC3, 8'h5A},
        {1'b1, 8'h00, 8'h11},
        {1'b1, 8'hFF, 8'hEE},
        {1'b0, 8'hFF, 8'hEE},
        {1'b0, 8'h77, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_ready;
    logic [DW-1:0] rsp_rdata;
    logic [1:0]    status;
    logic [PW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n;
    logic [DW-1:0] dram_dq_out;
    logic          dram_dq_oe;
    logic [DW-1:0] dram_dq_in;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dram_refresh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REF_INTERVAL(INT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .status(status),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_oe_n(dram_oe_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    // behavioural DRAM array, sampled away from the active edge
    logic [DW-1:0] mem [256];
    logic [PW-1:0] m_row, m_col;
    logic          prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;
    int            ref_count = 0, ref_seq_err = 0, viol = 0, writes_seen = 0;
    logic [PW-1:0] last_ref_row = '0;
    logic          have_ref = 1'b0;

    assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[{m_row, m_col}] : 'z;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                m_row   <= dram_addr;
                saw_cas <= 1'b0;
            end
            if (prev_cas && !dram_cas_n) begin
                m_col   <= dram_addr;
                saw_cas <= 1'b1;
            end
            if (!prev_ras && dram_ras_n && !saw_cas) begin
                ref_count <= ref_count + 1;
                if (have_ref && m_row != last_ref_row + 1'b1)
                    ref_seq_err <= ref_seq_err + 1;
                last_ref_row <= m_row;
                have_ref     <= 1'b1;
            end
            if (!dram_cas_n && !dram_we_n && dram_dq_oe) begin
                mem[{m_row, m_col}] <= dram_dq_out;
                if (prev_cas == 1'b0 && !dram_cas_n) writes_seen <= writes_seen;
            end
            // R3 / R4 / R7 pin rule monitor
            if ((!dram_cas_n && dram_ras_n) || (!dram_oe_n && !dram_we_n) ||
                (status == 2'd2 && !dram_cas_n) ||
                (!dram_we_n && !dram_dq_oe))
                viol <= viol + 1;
            prev_ras <= dram_ras_n;
            prev_cas <= dram_cas_n;
        end
    end

    logic [DW-1:0] exp_mem [256];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_access(input bit w, input logic [AW-1:0] a,
                             input logic [DW-1:0] d,
                             output logic [DW-1:0] rd, output int lat);
        int guard = 0;
        @(negedge clk);
        while (status != 2'd0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        lat = 0;
        rd  = '0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_ready) begin
                rd = rsp_rdata;
                break;
            end
            if (lat > 200) break;
        end
        @(negedge clk);
        check(!rsp_ready, "R5 ready one cycle", int'(rsp_ready), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        int lat;
        int rc0;
        int guard;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n, "R1 strobes high",
              {dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}, 4'hF);
        check(status == 2'd0, "R1 status idle", status, 0);
        check(!rsp_ready, "R1 ready low", rsp_ready, 0);
        rst_n = 1'b1;

        // table walk: R2, R4, R5
        for (int v = 0; v < NV; v++) begin
            logic          w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            {w, a, d} = VEC[v];
            do_access(w, a, d, rd, lat);
            check(lat == LAT + 1, "R5 latency", lat, LAT + 1);
            check(m_row == a[7:4] && m_col == a[3:0], "R2 row upper col lower",
                  {m_row, m_col}, a);
            if (w) begin
                exp_mem[a] = d;
                check(mem[a] == d, "R4 write stored", mem[a], d);
            end else begin
                check(rd == d && rd == exp_mem[a], "R5 read data", rd, d);
            end
        end

        // R6: status during an access
        fork
            do_access(1'b0, 8'h3C, 8'h00, rd, lat);
            begin
                repeat (3) @(negedge clk);
                check(status == 2'd1, "R6 status access", status, 1);
            end
        join

        // R7: refresh cadence and row sequence while idle
        rc0 = ref_count;
        repeat (INT * 5) @(negedge clk);
        check(ref_count - rc0 >= 4 && ref_count - rc0 <= 6, "R7 refresh count",
              ref_count - rc0, 5);
        check(ref_seq_err == 0, "R7 refresh row increments", ref_seq_err, 0);

        // R6: strobe during refresh is ignored
        guard = 0;
        while (status != 2'd2 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        check(status == 2'd2, "R6 refresh status seen", status, 2);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h5E; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (status != 2'd0 && guard < 200) begin
            @(negedge clk);
            check(!rsp_ready, "R6 no access from ignored strobe", rsp_ready, 0);
            guard++;
        end
        repeat (LAT + 4) @(negedge clk);
        check(mem[8'h5E] == 8'h00, "R6 ignored write not stored", mem[8'h5E], 0);

        // R8: back-to-back traffic across several refreshes
        rc0 = ref_count;
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            a = AW'(i * 37 + 5);
            exp_mem[a] = DW'(i * 13 + 1);
            do_access(1'b1, a, exp_mem[a], rd, lat);
        end
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            a = AW'(i * 37 + 5);
            do_access(1'b0, a, 8'h00, rd, lat);
            check(rd == exp_mem[a], "R8 data under refresh", rd, exp_mem[a]);
        end
        check(ref_count - rc0 >= 8, "R8 refresh still serviced", ref_count - rc0, 8);
        check(ref_seq_err == 0, "R7 row sequence after traffic", ref_seq_err, 0);
        check(viol == 0, "R3 R4 pin ordering rules", viol, 0);

        finish_run();
    end

endmodule